// File: doc/BRIEF.md
# Shutdown Entry and Pad-Hold Controller

This block governs the way into the deepest low-power mode and keeps the I/O pads quiet on the way in and out of it. Software arms shutdown by writing a 16-bit key through a small 32-bit register port. A matching key starts a short entry sequence. That sequence raises a single-cycle request towards the power sequencer and engages the pad hold at the same time. While the hold is engaged, every pad output value and output-enable is frozen in a bank of hold registers. The input direction stays transparent throughout.

The controller is built around a three-state machine. `ST_RUN` is normal operation, the only state in which register writes and standby wakeups are accepted. `ST_ENTER` lasts one cycle and is the cycle in which `shutdown_req` is high. `ST_OFF` waits for the shutdown wakeup. There are three transitions. RUN→ENTER happens on a key match. ENTER→OFF is unconditional. OFF→RUN happens on a wakeup marked as coming from shutdown.

After that wakeup the pads stay held. Two sticky flags record that the last wakeup came from shutdown and whether an I/O event caused it. Software restores its pad setup and then writes the release bit. That write drops the hold and clears both flags. A 2-bit wakeup-source field tells a reset, a standby wakeup and a shutdown wakeup apart.

Top module: `sdn_pad_ctrl`

## Requirements
- R1: After reset the release bit (bit 0 at offset 0x0) is 0, so `pad_hold` is 1 and `pad_out`/`pad_oe` are all zero. The flags at offset 0x4 (bit 0 shutdown-wake, bit 1 I/O-wake) are 0. The source field at offset 0x8 bits [1:0] reads 0b01 (reset). `shutdown_req` is 0.
- R2: In `ST_RUN`, a write to offset 0xC whose bits [15:0] equal `KEY_VAL` (default 0xA7D5) raises `shutdown_req` for exactly one cycle, starting at the clock edge that takes the write. Bits [31:16] of that write are ignored.
- R3: A write to offset 0xC whose bits [15:0] differ from `KEY_VAL` has no effect: `shutdown_req` stays 0, the pads stay released and the release bit still reads 1.
- R4: Accepting the key clears the release bit at the same edge, so `pad_hold` is high while `shutdown_req` is high. While in `ST_ENTER` or `ST_OFF`, all register writes are ignored.
- R5: While `pad_hold` is 1, `pad_out`/`pad_oe` keep the core values captured at the last edge before the hold engaged. `core_in` always equals `pad_in`.
- R6: While `pad_hold` is 0, `pad_out`/`pad_oe` follow `core_out`/`core_oe` one clock later.
- R7: In `ST_RUN`, writing 1 to the release bit drops `pad_hold` and clears both flags. Writing 0 to it engages the hold again.
- R8: A `wake_vld` pulse with `wake_from_sd`=1 in `ST_OFF` returns to `ST_RUN`. It sets the shutdown-wake flag, copies `wake_io` into the I/O-wake flag and sets the source field to 0b11. The pads stay held until the release write. The source field never reads the reserved code 0b00.
- R9: A `wake_vld` pulse with `wake_from_sd`=0 in `ST_RUN` sets the source field to 0b10 and leaves the flags unchanged. A shutdown-marked wakeup in `ST_RUN` is ignored, and so is a standby-marked wakeup in `ST_OFF`.
- R10: Reads of the key offset 0xC, of unused bits and of any other offset return zero.
- R11: A valid key write and a standby wakeup in the same `ST_RUN` cycle both take effect: shutdown entry starts and the source field becomes 0b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| wake_vld | input | 1 | Wakeup event pulse |
| wake_from_sd | input | 1 | Wakeup is from shutdown (1) or standby (0) |
| wake_io | input | 1 | Shutdown wakeup was caused by an I/O event |
| shutdown_req | output | 1 | One-cycle shutdown request |
| pad_hold | output | 1 | Pad hold engaged |
| core_out | input | NPADS | Output values from the core |
| core_oe | input | NPADS | Output enables from the core |
| pad_out | output | NPADS | Output values driven to the pads |
| pad_oe | output | NPADS | Output enables driven to the pads |
| pad_in | input | NPADS | Values received from the pads |
| core_in | output | NPADS | Received values passed to the core |

## Verification
A key write and a standby wakeup can both arrive in the same `ST_RUN` cycle. The key moves the state machine, and the wakeup updates the source register in the register logic. The bench first sets the source field to 0b11 with a shutdown wakeup and a release write. It then drives the key write and a standby-marked `wake_vld` on the same falling edge. It judges the result by seeing `shutdown_req` and `pad_hold` high one edge later, and the source field read back as 0b10 rather than 0b11.

// File: rtl/sdn_pkg.sv
package sdn_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    // register byte offsets
    localparam logic [ADDR_W-1:0] OFS_CTL  = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_STAT = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_SRC  = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_KEY  = 4'hC;

    // wakeup source codes
    localparam logic [1:0] SRC_RESET = 2'b01;
    localparam logic [1:0] SRC_STBY  = 2'b10;
    localparam logic [1:0] SRC_SDN   = 2'b11;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ENTER = 2'd1,
        ST_OFF   = 2'd2
    } sdn_state_e;

endpackage

// File: rtl/sdn_fsm.sv
module sdn_fsm
    import sdn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_hit,
    input  logic       sd_wake,
    output sdn_state_e state,
    output logic       shutdown_req,
    output logic       sw_open,
    output logic       in_off
);

    sdn_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (key_hit) state_d = ST_ENTER;
            ST_ENTER: state_d = ST_OFF;
            ST_OFF:   if (sd_wake) state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Moore outputs
    always_comb begin
        shutdown_req = 1'b0;
        sw_open      = 1'b0;
        in_off       = 1'b0;
        unique case (state_q)
            ST_RUN:   sw_open      = 1'b1;
            ST_ENTER: shutdown_req = 1'b1;
            ST_OFF:   in_off       = 1'b1;
            default:  sw_open      = 1'b0;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/sdn_regs.sv
module sdn_regs
    import sdn_pkg::*;
#(
    parameter int              KEY_W   = 16,
    parameter logic [KEY_W-1:0] KEY_VAL = 16'hA7D5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sw_open,
    input  logic              in_off,
    input  logic              wake_vld,
    input  logic              wake_from_sd,
    input  logic              wake_io,
    output logic              key_hit,
    output logic              sd_wake,
    output logic              release_q,
    output logic              flag_sd,
    output logic              flag_io,
    output logic [1:0]        wake_src
);

    logic wr_ctl, key_take, sb_wake;

    assign key_hit  = reg_wr && (reg_addr == OFS_KEY) &&
                      (reg_wdata[KEY_W-1:0] == KEY_VAL);
    assign key_take = sw_open && key_hit;
    assign wr_ctl   = sw_open && reg_wr && (reg_addr == OFS_CTL);
    assign sd_wake  = in_off && wake_vld && wake_from_sd;
    assign sb_wake  = sw_open && wake_vld && !wake_from_sd;

    // pad release bit: cleared by shutdown entry, written by software
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        release_q <= 1'b0;
        else if (key_take) release_q <= 1'b0;
        else if (wr_ctl)   release_q <= reg_wdata[0];
    end

    // sticky wakeup flags, cleared when pads are released
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_sd <= 1'b0;
            flag_io <= 1'b0;
        end else if (sd_wake) begin
            flag_sd <= 1'b1;
            flag_io <= wake_io;
        end else if (wr_ctl && reg_wdata[0]) begin
            flag_sd <= 1'b0;
            flag_io <= 1'b0;
        end
    end

    // wakeup source field
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       wake_src <= SRC_RESET;
        else if (sd_wake) wake_src <= SRC_SDN;
        else if (sb_wake) wake_src <= SRC_STBY;
    end

    // read mux; the key offset is write-only and reads zero
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTL:  reg_rdata[0]   = release_q;
            OFS_STAT: reg_rdata[1:0] = {flag_io, flag_sd};
            OFS_SRC:  reg_rdata[1:0] = wake_src;
            default:  reg_rdata      = '0;
        endcase
    end

endmodule

// File: rtl/sdn_padbank.sv
module sdn_padbank #(
    parameter int NPADS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [NPADS-1:0] core_out,
    input  logic [NPADS-1:0] core_oe,
    input  logic [NPADS-1:0] pad_in,
    output logic [NPADS-1:0] pad_out,
    output logic [NPADS-1:0] pad_oe,
    output logic [NPADS-1:0] core_in
);

    for (genvar i = 0; i < NPADS; i++) begin : g_pad
        logic out_q, oe_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_q <= 1'b0;
                oe_q  <= 1'b0;
            end else if (!hold) begin
                out_q <= core_out[i];
                oe_q  <= core_oe[i];
            end
        end
        assign pad_out[i] = out_q;
        assign pad_oe[i]  = oe_q;
        assign core_in[i] = pad_in[i];
    end

endmodule

// File: rtl/sdn_pad_ctrl.sv
module sdn_pad_ctrl
    import sdn_pkg::*;
#(
    parameter int          NPADS   = 8,
    parameter logic [15:0] KEY_VAL = 16'hA7D5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              wake_vld,
    input  logic              wake_from_sd,
    input  logic              wake_io,
    output logic              shutdown_req,
    output logic              pad_hold,
    input  logic [NPADS-1:0]  core_out,
    input  logic [NPADS-1:0]  core_oe,
    output logic [NPADS-1:0]  pad_out,
    output logic [NPADS-1:0]  pad_oe,
    input  logic [NPADS-1:0]  pad_in,
    output logic [NPADS-1:0]  core_in
);

    sdn_state_e state;
    logic       sw_open, in_off, key_hit, sd_wake;
    logic       release_q, flag_sd, flag_io;
    logic [1:0] wake_src;

    sdn_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .key_hit      (key_hit),
        .sd_wake      (sd_wake),
        .state        (state),
        .shutdown_req (shutdown_req),
        .sw_open      (sw_open),
        .in_off       (in_off)
    );

    sdn_regs #(
        .KEY_W   (16),
        .KEY_VAL (KEY_VAL)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .sw_open      (sw_open),
        .in_off       (in_off),
        .wake_vld     (wake_vld),
        .wake_from_sd (wake_from_sd),
        .wake_io      (wake_io),
        .key_hit      (key_hit),
        .sd_wake      (sd_wake),
        .release_q    (release_q),
        .flag_sd      (flag_sd),
        .flag_io      (flag_io),
        .wake_src     (wake_src)
    );

    assign pad_hold = !release_q;

    sdn_padbank #(.NPADS(NPADS)) u_pads (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (pad_hold),
        .core_out (core_out),
        .core_oe  (core_oe),
        .pad_in   (pad_in),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .core_in  (core_in)
    );

endmodule

// File: rtl/sdn_pad_ctrl_chk.sv
module sdn_pad_ctrl_chk #(
    parameter int NPADS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             shutdown_req,
    input logic             pad_hold,
    input logic [NPADS-1:0] pad_out,
    input logic [NPADS-1:0] pad_oe,
    input logic             flag_sd,
    input logic             flag_io,
    input logic [1:0]       wake_src
);

    p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |=> !shutdown_req);

    p_req_holds_pads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> pad_hold);

    p_hold_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_hold && $past(pad_hold)) |-> ($stable(pad_out) && $stable(pad_oe)));

    p_release_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pad_hold) |-> (!flag_sd && !flag_io));

    p_flag_keeps_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_sd |-> pad_hold);

    p_src_not_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_src != 2'b00);

endmodule

bind sdn_pad_ctrl sdn_pad_ctrl_chk #(.NPADS(NPADS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .shutdown_req (shutdown_req),
    .pad_hold     (pad_hold),
    .pad_out      (pad_out),
    .pad_oe       (pad_oe),
    .flag_sd      (flag_sd),
    .flag_io      (flag_io),
    .wake_src     (wake_src)
);

// File: tb/test_sdn_pad_ctrl.sv
module test_sdn_pad_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;
    localparam logic [3:0] A_CTL = 4'h0, A_STAT = 4'h4, A_SRC = 4'h8, A_KEY = 4'hC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          wake_vld = 1'b0, wake_from_sd = 1'b0, wake_io = 1'b0;
    logic          shutdown_req, pad_hold;
    logic [NP-1:0] core_out = '0, core_oe = '0, pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe, core_in;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdn_pad_ctrl #(.NPADS(NP)) i_sdn_pad_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake_vld(wake_vld),
        .wake_from_sd(wake_from_sd), .wake_io(wake_io),
        .shutdown_req(shutdown_req), .pad_hold(pad_hold),
        .core_out(core_out), .core_oe(core_oe), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_in(pad_in), .core_in(core_in)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // drive at a falling edge, take it on the rising edge, return at the next falling edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic wake(input logic sd, input logic io);
        @(negedge clk);
        wake_vld = 1'b1; wake_from_sd = sd; wake_io = io;
        @(negedge clk);
        wake_vld = 1'b0; wake_from_sd = 1'b0; wake_io = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 hold after reset", {31'b0, pad_hold}, 1);
        check("R1 req after reset", {31'b0, shutdown_req}, 0);
        check("R1 pads after reset", {16'b0, pad_out, pad_oe}, 0);
        rd(A_CTL, d);  check("R1 release bit", d, 0);
        rd(A_STAT, d); check("R1 flags", d, 0);
        rd(A_SRC, d);  check("R1 source reset code", d, 1);
        core_out = 8'h3C; core_oe = 8'hFF; pad_in = 8'h5A;
        @(negedge clk); #1;
        check("R5 pads held at reset", {16'b0, pad_out, pad_oe}, 0);
        check("R5 input transparent", {24'b0, core_in}, 32'h5A);
    endtask

    task automatic t_release;
        logic [31:0] d;
        wr(A_CTL, 32'h1); #1;
        check("R7 release drops hold", {31'b0, pad_hold}, 0);
        @(negedge clk); #1;
        check("R6 pads follow core", {16'b0, pad_out, pad_oe}, 32'h3CFF);
        core_out = 8'h81; core_oe = 8'hF0;
        @(negedge clk); #1;
        check("R6 pads follow new core", {16'b0, pad_out, pad_oe}, 32'h81F0);
        rd(A_CTL, d); check("R7 release reads 1", d, 1);
    endtask

    task automatic t_bad_key;
        logic [31:0] d;
        wr(A_KEY, 32'h0000_A7D4); #1;
        check("R3 wrong key no request", {31'b0, shutdown_req}, 0);
        wr(A_KEY, 32'hA7D5_0000); #1;
        check("R3 key in upper half rejected", {31'b0, shutdown_req}, 0);
        check("R3 pads still released", {31'b0, pad_hold}, 0);
        rd(A_CTL, d); check("R3 release unchanged", d, 1);
        rd(A_KEY, d); check("R10 key offset reads zero", d, 0);
        rd(4'h2, d);  check("R10 unused offset reads zero", d, 0);
    endtask

    task automatic t_shutdown;
        logic [31:0] d;
        @(negedge clk);
        core_out = 8'h66; core_oe = 8'h0F;
        reg_wr = 1'b1; reg_addr = A_KEY; reg_wdata = 32'hFFFF_A7D5;
        @(negedge clk); #1;
        check("R2 request on valid key", {31'b0, shutdown_req}, 1);
        check("R4 hold with request", {31'b0, pad_hold}, 1);
        reg_wr = 1'b0; core_out = 8'h99; core_oe = 8'hF0; pad_in = 8'hC3;
        @(negedge clk); #1;
        check("R2 request lasts one cycle", {31'b0, shutdown_req}, 0);
        check("R5 pads frozen", {16'b0, pad_out, pad_oe}, 32'h660F);
        check("R5 input transparent in hold", {24'b0, core_in}, 32'hC3);
        wr(A_CTL, 32'h1); #1;
        check("R4 release ignored in shutdown", {31'b0, pad_hold}, 1);
        wr(A_KEY, 32'h0000_A7D5); #1;
        check("R4 key ignored in shutdown", {31'b0, shutdown_req}, 0);
        wake(1'b0, 1'b0);
        rd(A_SRC, d); check("R9 standby wake ignored in shutdown", d, 1);
    endtask

    task automatic t_wake_sd(input logic io);
        logic [31:0] d;
        wake(1'b1, io); #1;
        rd(A_SRC, d);  check("R8 source shutdown code", d, 3);
        rd(A_STAT, d); check("R8 wake flags", d, {30'b0, io, 1'b1});
        check("R8 hold kept after wake", {31'b0, pad_hold}, 1);
        check("R8 pads unchanged after wake", {16'b0, pad_out, pad_oe}, 32'h660F);
        wr(A_CTL, 32'h1); #1;
        rd(A_STAT, d); check("R7 release clears flags", d, 0);
        check("R7 hold dropped", {31'b0, pad_hold}, 0);
        @(negedge clk); #1;
        check("R6 pads follow after release", {16'b0, pad_out, pad_oe}, {16'b0, core_out, core_oe});
    endtask

    task automatic t_collision;
        logic [31:0] d;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_KEY; reg_wdata = 32'h0000_A7D5;
        wake_vld = 1'b1; wake_from_sd = 1'b0;
        @(negedge clk); #1;
        reg_wr = 1'b0; wake_vld = 1'b0;
        check("R11 request with standby wake", {31'b0, shutdown_req}, 1);
        check("R11 hold engaged", {31'b0, pad_hold}, 1);
        rd(A_SRC, d); check("R11 source standby code", d, 2);
        core_out = 8'h55;
        // second shutdown wake, no I/O event; held pads are last released values
        wake(1'b1, 1'b0); #1;
        rd(A_STAT, d); check("R8 flags without io", d, 1);
        wr(A_CTL, 32'h1);
    endtask

    task automatic t_standby;
        logic [31:0] d;
        wake(1'b0, 1'b0); #1;
        rd(A_SRC, d);  check("R9 standby code", d, 2);
        rd(A_STAT, d); check("R9 flags untouched", d, 0);
        wake(1'b1, 1'b1); #1;
        rd(A_SRC, d);  check("R9 shutdown wake ignored in run", d, 2);
        rd(A_STAT, d); check("R9 flags stay clear", d, 0);
        wr(A_CTL, 32'h0); #1;
        check("R7 writing 0 re-engages hold", {31'b0, pad_hold}, 1);
    endtask

    initial begin
        t_reset();
        t_release();
        t_bad_key();
        t_shutdown();
        t_wake_sd(1'b1);
        // collision needs source at 0b11 first (set by t_wake_sd)
        t_collision();
        t_standby();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule